// File: doc/BRIEF.md
# Four-Phase Fetch-Execute Sequencer

This block produces the instruction timing for a small two-stage processor core. A free-running phase counter splits the system clock into four non-overlapping phase strobes, T1 to T4. Four strobes make one instruction cycle. In every instruction cycle the core fetches the next instruction word while the word fetched in the previous cycle executes. In steady state one instruction therefore completes per instruction cycle.

The execute stage reports two flags: a taken control transfer, and a conditional skip whose condition was met. The sequencer samples both flags only in phase T4. If the word that is executing is a real instruction and either flag is set, the sequencer discards the word that was just prefetched. It loads a no-op in its place and marks the next instruction cycle as a bubble. During a bubble cycle the commit strobe stays low, so execute writes no state. The flags that execute raises during a bubble are ignored. An instruction that redirects flow therefore costs exactly two instruction cycles.

The reset input is asynchronous and active low. Its release is synchronised inside the block. Decoding, the ALU, the program counter and the memories are outside this block.

Top module: `ifetch_sequencer`

## Requirements
- R1: `phase_o` is one-hot at every clock. Bit 0 is T1 and bit 3 is T4. The strobes advance one position per clock in the order T1, T2, T3, T4, T1, so one instruction cycle spans exactly four clocks.
- R2: While reset is asserted, and for two clocks after `rst_ni` rises (synchroniser latency), the outputs hold their reset values: `phase_o` = T1, `bubble_o` = 1, `ir_o` = NOP_WORD (default 0), and `fetch_stb_o` = `commit_o` = 0. The first instruction cycle after reset is therefore a bubble.
- R3: `fetch_stb_o` is high exactly during T4. The `instr_i` value present at the clock edge that closes T4 appears on `ir_o` from the following T1. It stays unchanged for that whole instruction cycle.
- R4: With both flags low, every fetched word is executed in the next instruction cycle and none is dropped, so one word completes per instruction cycle.
- R5: When `xfer_taken_i` is high at T4 of a non-bubble cycle, the next cycle is a bubble: `bubble_o` = 1 and `ir_o` = NOP_WORD. The word fetched in that T4 is discarded. The word fetched during the bubble executes in the cycle after it.
- R6: When `skip_taken_i` is high at T4 of a non-bubble cycle, the next cycle is a bubble with the same effect as R5.
- R7: When `skip_taken_i` is low at T4, the prefetched word executes next with no extra cycle.
- R8: Flag values during T1, T2 and T3 have no effect. Only the level at T4 counts.
- R9: Flags raised at T4 of a bubble cycle are ignored. A bubble is always followed by a non-bubble cycle.
- R10: `commit_o` is high only during T4 of a non-bubble cycle. It stays low throughout every bubble cycle.
- R11: Both flags high together at T4 insert a single bubble, not two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| instr_i | input | IW | Instruction word fetched this cycle, captured at the edge that closes T4 |
| xfer_taken_i | input | 1 | Execute reports a taken control transfer |
| skip_taken_i | input | 1 | Execute reports a conditional skip whose condition is met |
| phase_o | output | 4 | One-hot phase strobes; bit 0 = T1 … bit 3 = T4 |
| fetch_stb_o | output | 1 | High during T4, when the fetched word is taken |
| ir_o | output | IW | Word handed to execute for the current instruction cycle |
| bubble_o | output | 1 | Current instruction cycle is a bubble |
| commit_o | output | 1 | Execute may write its results (T4 of a non-bubble cycle) |

## Verification
`phase_o` moves on every clock. `fetch_stb_o` and `commit_o` follow it with no added delay. `ir_o` and `bubble_o` change only at the edge that closes T4, so a flag or word driven in T4 shows on them from the next T1 onward. The bench drives inputs and samples outputs at the falling clock edge. It walks each instruction cycle phase by phase, applies the word and flags in the T4 half-period, and checks `ir_o` and `bubble_o` one clock later in T1. The extra two-clock latency of reset release is checked by confirming that T1 persists across those two edges before the rotation starts.

// File: rtl/ifseq_pkg.sv
package ifseq_pkg;

  localparam int unsigned NUM_PHASES = 4;
  localparam int unsigned PHASE_W    = $clog2(NUM_PHASES);

  typedef enum logic [PHASE_W-1:0] {
    PH_T1 = 2'd0,
    PH_T2 = 2'd1,
    PH_T3 = 2'd2,
    PH_T4 = 2'd3
  } phase_e;

endpackage

// File: rtl/ifseq_rst_sync.sv
module ifseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/ifseq_phase_gen.sv
module ifseq_phase_gen
  import ifseq_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic [NUM_PHASES-1:0] strobe_o,
  output logic                  last_o
);

  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    unique case (phase_q)
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = PH_T3;
      PH_T3:   phase_d = PH_T4;
      default: phase_d = PH_T1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_T1;
    end else begin
      phase_q <= phase_d;
    end
  end

  generate
    for (genvar i = 0; i < NUM_PHASES; i++) begin : g_strobe
      assign strobe_o[i] = (phase_q == PHASE_W'(i));
    end
  endgenerate

  assign last_o = strobe_o[NUM_PHASES-1];

  // R1: exactly one strobe active
  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(strobe_o) == 1);

  // R1: T4 wraps to T1
  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o[NUM_PHASES-1] |=> strobe_o[0]);

  // R1: T1 is followed by T2
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o[0] |=> strobe_o[1]);

endmodule

// File: rtl/ifseq_flush_ctl.sv
module ifseq_flush_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic xfer_i,
  input  logic skip_i,
  output logic bubble_o,
  output logic squash_o
);

  logic bubble_q;
  logic bubble_d;
  logic redirect;

  // A bubble cannot redirect: its flags are ignored.
  assign redirect = !bubble_q && (xfer_i || skip_i);

  always_comb begin
    bubble_d = bubble_q;
    if (adv_i) begin
      bubble_d = redirect;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bubble_q <= 1'b1;
    end else begin
      bubble_q <= bubble_d;
    end
  end

  assign bubble_o = bubble_q;
  assign squash_o = adv_i && redirect;

  // R5, R6: a redirect at T4 of a real instruction makes the next cycle a bubble
  a_r5_redirect_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !bubble_q && (xfer_i || skip_i)) |=> bubble_q);

  // R9: bubbles never chain
  a_r9_no_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && bubble_q) |=> !bubble_q);

  // R8: state changes only at the cycle boundary
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(bubble_q));

endmodule

// File: rtl/ifseq_ir_stage.sv
module ifseq_ir_stage #(
  parameter int unsigned    IW       = 14,
  parameter logic [IW-1:0]  NOP_WORD = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          squash_i,
  input  logic [IW-1:0] word_i,
  output logic [IW-1:0] ir_o
);

  logic [IW-1:0] ir_q;
  logic [IW-1:0] ir_d;

  always_comb begin
    ir_d = ir_q;
    if (load_i) begin
      ir_d = squash_i ? NOP_WORD : word_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q <= NOP_WORD;
    end else begin
      ir_q <= ir_d;
    end
  end

  assign ir_o = ir_q;

  // R3: word held for the whole instruction cycle
  a_r3_ir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(ir_q));

  // R5: a squashed fetch becomes a no-op
  a_r5_squash_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && squash_i) |=> (ir_q == NOP_WORD));

endmodule

// File: rtl/ifetch_sequencer.sv
module ifetch_sequencer
  import ifseq_pkg::*;
#(
  parameter int unsigned   IW          = 14,
  parameter logic [IW-1:0] NOP_WORD    = '0,
  parameter int unsigned   RST_STAGES  = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [IW-1:0]         instr_i,
  input  logic                  xfer_taken_i,
  input  logic                  skip_taken_i,
  output logic [NUM_PHASES-1:0] phase_o,
  output logic                  fetch_stb_o,
  output logic [IW-1:0]         ir_o,
  output logic                  bubble_o,
  output logic                  commit_o
);

  logic rst_sync_n;
  logic cycle_end;
  logic squash;

  ifseq_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  ifseq_phase_gen u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .strobe_o (phase_o),
    .last_o   (cycle_end)
  );

  ifseq_flush_ctl u_flush (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .adv_i    (cycle_end),
    .xfer_i   (xfer_taken_i),
    .skip_i   (skip_taken_i),
    .bubble_o (bubble_o),
    .squash_o (squash)
  );

  ifseq_ir_stage #(
    .IW       (IW),
    .NOP_WORD (NOP_WORD)
  ) u_ir (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .load_i   (cycle_end),
    .squash_i (squash),
    .word_i   (instr_i),
    .ir_o     (ir_o)
  );

  assign fetch_stb_o = cycle_end;
  assign commit_o    = cycle_end && !bubble_o;

  // R10: a bubble never commits
  a_r10_no_commit_in_bubble: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    bubble_o |-> !commit_o);

endmodule

// File: tb/ifetch_sequencer_tb.sv
`timescale 1ns/1ps
module ifetch_sequencer_tb_top;

  localparam int unsigned   IW  = 14;
  localparam logic [IW-1:0] NOP = '0;

  logic          clk;
  logic          rst_n;
  logic [IW-1:0] instr;
  logic          xfer;
  logic          skip;
  logic [3:0]    phase;
  logic          fetch_stb;
  logic [IW-1:0] ir;
  logic          bubble;
  logic          commit;

  int checks;
  int errors;
  bit done;

  logic [IW-1:0] exp_ir;
  logic          exp_bubble;

  ifetch_sequencer #(
    .IW         (IW),
    .NOP_WORD   (NOP),
    .RST_STAGES (2)
  ) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .instr_i      (instr),
    .xfer_taken_i (xfer),
    .skip_taken_i (skip),
    .phase_o      (phase),
    .fetch_stb_o  (fetch_stb),
    .ir_o         (ir),
    .bubble_o     (bubble),
    .commit_o     (commit)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Walks one instruction cycle from its T1 (at a falling edge) to the next T1.
  task automatic step_cycle(input string req, input logic [IW-1:0] word,
                            input logic xf, input logic sk,
                            input logic early_xf, input logic early_sk);
    logic flush;
    xfer = early_xf;
    skip = early_sk;
    for (int p = 0; p < 4; p++) begin
      if (p != 0) @(negedge clk);
      check("R1", "phase", 32'(phase), 32'(4'b0001 << p));
      check("R3", "ir_hold", 32'(ir), 32'(exp_ir));
      check("R3", "fetch_stb", 32'(fetch_stb), 32'(p == 3));
      check("R10", "commit", 32'(commit), 32'((p == 3) && !exp_bubble));
      if (p == 3) begin
        instr = word;
        xfer  = xf;
        skip  = sk;
      end
    end
    @(negedge clk);
    flush      = !exp_bubble && (xf || sk);
    exp_ir     = flush ? NOP : word;
    exp_bubble = flush;
    check(req, "ir_next", 32'(ir), 32'(exp_ir));
    check(req, "bubble_next", 32'(bubble), 32'(exp_bubble));
    check("R1", "phase_wrap", 32'(phase), 32'h1);
    xfer = 1'b0;
    skip = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    instr = '0;
    xfer  = 1'b0;
    skip  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2", "phase", 32'(phase), 32'h1);
    check("R2", "bubble", 32'(bubble), 32'h1);
    check("R2", "ir", 32'(ir), 32'(NOP));
    check("R2", "fetch_stb", 32'(fetch_stb), 32'h0);
    check("R2", "commit", 32'(commit), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", "phase_sync1", 32'(phase), 32'h1);
    @(negedge clk);
    check("R2", "phase_sync2", 32'(phase), 32'h1);
    exp_ir     = NOP;
    exp_bubble = 1'b1;
  endtask

  task automatic t_stream();
    step_cycle("R2", 14'h0101, 1'b0, 1'b0, 1'b0, 1'b0);
    step_cycle("R4", 14'h0222, 1'b0, 1'b0, 1'b0, 1'b0);
    step_cycle("R4", 14'h0333, 1'b0, 1'b0, 1'b0, 1'b0);
    step_cycle("R4", 14'h3FFF, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_transfer();
    step_cycle("R5", 14'h0A0A, 1'b1, 1'b0, 1'b0, 1'b0);
    step_cycle("R5", 14'h0B0B, 1'b0, 1'b0, 1'b0, 1'b0);
    step_cycle("R5", 14'h0C0C, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_skip();
    step_cycle("R6", 14'h1111, 1'b0, 1'b1, 1'b0, 1'b0);
    step_cycle("R6", 14'h1212, 1'b0, 1'b0, 1'b0, 1'b0);
    step_cycle("R6", 14'h1313, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_skip_not_met();
    step_cycle("R7", 14'h2020, 1'b0, 1'b0, 1'b0, 1'b0);
    step_cycle("R7", 14'h2121, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_early_flags();
    step_cycle("R8", 14'h2A2A, 1'b0, 1'b0, 1'b1, 1'b1);
    step_cycle("R8", 14'h2B2B, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_bubble_flags();
    step_cycle("R9", 14'h3030, 1'b1, 1'b0, 1'b0, 1'b0);
    step_cycle("R9", 14'h3131, 1'b1, 1'b1, 1'b0, 1'b0);
    step_cycle("R9", 14'h3232, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_both_flags();
    step_cycle("R11", 14'h3434, 1'b1, 1'b1, 1'b0, 1'b0);
    step_cycle("R11", 14'h3535, 1'b0, 1'b0, 1'b0, 1'b0);
    step_cycle("R11", 14'h3636, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    t_reset();
    t_stream();
    t_transfer();
    t_skip();
    t_skip_not_met();
    t_early_flags();
    t_bubble_flags();
    t_both_flags();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule